// File: doc/BRIEF.md
# Multidrop 9-bit UART receiver

This block receives asynchronous serial characters on a shared multidrop line. Every character carries a ninth bit after the eight data bits. A ninth bit of 1 marks the byte as a node address and 0 marks it as payload. The block compares address bytes against a programmed local node address and applies one of several filtering policies. The policy decides which received bytes reach the output stream and so raise the receive interrupt. With the multidrop function switched off, the block is a plain 8-bit receiver that delivers every well-formed byte.

Received bytes leave through a valid/ready stream: `out_valid` is the interrupt request and `out_ready` is the read strobe. The serial line cannot be stalled, so back-pressure is limited. A byte is held with `out_valid` high until a cycle with `out_ready` high. If a new byte is accepted while one is still held, the new byte overwrites it and `overrun` is set. Status flags report whether the last well-formed byte was an address and whether the last character had a bad stop bit.

Top module: `mdrop_rx`

## Requirements
- R1: The idle line is high. A character is a low start bit, then eight data bits sent least significant bit first, then the ninth bit when `mp_en` is 1, then the stop bit or bits, which are high. Each bit lasts 16 `os_tick` pulses and is sampled near its middle. An accepted byte appears on `out_data`.
- R2: A falling edge whose line is high again at the middle of the start bit is discarded as noise, and no byte is produced.
- R3: With `mp_en` = 0 no ninth bit is expected. Every well-formed byte is accepted, and `new_frame` reads 0.
- R4: With `mp_en` = 1 and `filt_mode` = 2'b00, every well-formed byte is accepted, whether it is an address or data.
- R5: With `filt_mode` = 2'b01, only address bytes (ninth bit 1) are accepted, and data bytes never are.
- R6: With `filt_mode` = 2'b10, an address byte equal to `node_addr` is accepted and arms a match. Data bytes are accepted only while the match is armed. An address byte that does not match disarms the match and is not accepted.
- R7: With `filt_mode` = 2'b11, address bytes are never accepted but still arm or disarm the match. Data bytes are accepted only while the match is armed.
- R8: `new_frame` equals the ninth bit of the most recent well-formed character.
- R9: A stop bit sampled low sets `frame_err`, drops the byte and disarms the match. `frame_err` clears on the next well-formed character.
- R10: With `two_stop` = 1, the second stop bit is checked as well, and a low second stop bit is a framing error.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable. A cycle with both high consumes the byte, and `out_valid` falls on the next cycle unless a new byte is accepted in that cycle.
- R12: A byte accepted while a byte is held and `out_ready` is low replaces the held byte and sets `overrun`. `overrun` clears on the next consuming handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial line, asynchronous, idle high |
| os_tick | input | 1 | Oversampling pulse, 16 per bit |
| mp_en | input | 1 | Enables the ninth bit and address filtering |
| filt_mode | input | 2 | Filtering policy (00 all, 01 address, 10 matched, 11 data after match) |
| node_addr | input | 8 | Local node address |
| two_stop | input | 1 | Expect two stop bits |
| out_ready | input | 1 | Read strobe / stream ready |
| out_valid | output | 1 | Interrupt request / stream valid |
| out_data | output | 8 | Held received byte |
| new_frame | output | 1 | Last well-formed character was an address |
| frame_err | output | 1 | Last character had a low stop bit |
| overrun | output | 1 | A held byte was overwritten |

## Verification
The assertions assume that `os_tick` is a single-cycle pulse and that the control inputs (`mp_en`, `filt_mode`, `node_addr`, `two_stop`) change only while the line is idle between characters. The filter-policy checks also rely on `out_ready` not being raised in the same cycle as a byte is accepted. The bench changes its controls only after a character has fully finished. It pulses `out_ready` for one cycle well clear of character ends, and it spaces bit edges exactly 16 ticks apart, so that mid-bit sampling never falls near a transition.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  typedef enum logic [1:0] {
    FM_ALL   = 2'b00,
    FM_ADDR  = 2'b01,
    FM_MATCH = 2'b10,
    FM_DATA  = 2'b11
  } filt_mode_e;
endpackage

// File: rtl/mdrop_rx_sync.sv
module mdrop_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mdrop_rx_deser.sv
module mdrop_rx_deser
  import mdrop_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx,
  input  logic          nine_en,
  input  logic          two_stop,
  output logic          done,
  output logic          ferr,
  output logic          mpbit,
  output logic [DW-1:0] data
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int BW   = $clog2(DW + 2);

  rx_state_e      st;
  logic [CW-1:0]  cnt;
  logic [BW-1:0]  bidx;
  logic [DW:0]    sh;
  logic           nine_q, stop2_q, second_q, prev_hi;
  logic [BW-1:0]  last_idx;

  assign last_idx = nine_q ? BW'(DW) : BW'(DW - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RX_IDLE;
      cnt      <= '0;
      bidx     <= '0;
      sh       <= '0;
      nine_q   <= 1'b0;
      stop2_q  <= 1'b0;
      second_q <= 1'b0;
      prev_hi  <= 1'b1;
      done     <= 1'b0;
      ferr     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) prev_hi <= rx;
      case (st)
        RX_IDLE: begin
          if (tick && !rx && prev_hi) begin
            st      <= RX_START;
            cnt     <= '0;
            sh      <= '0;
            nine_q  <= nine_en;
            stop2_q <= two_stop;
          end
        end
        RX_START: begin
          if (tick) begin
            if (cnt == CW'(HALF - 1)) begin
              cnt  <= '0;
              bidx <= '0;
              st   <= rx ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (cnt == CW'(OSR - 1)) begin
              cnt      <= '0;
              sh[bidx] <= rx;
              if (bidx == last_idx) begin
                st       <= RX_STOP;
                second_q <= 1'b0;
              end else begin
                bidx <= bidx + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (cnt == CW'(OSR - 1)) begin
              cnt <= '0;
              if (!rx) begin
                done <= 1'b1;
                ferr <= 1'b1;
                st   <= RX_IDLE;
              end else if (stop2_q && !second_q) begin
                second_q <= 1'b1;
              end else begin
                done <= 1'b1;
                ferr <= 1'b0;
                st   <= RX_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign data  = sh[DW-1:0];
  assign mpbit = nine_q & sh[DW];

  // R2: a start bit that is high at mid-bit returns to idle without a result
  assert_noise_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_START && tick && cnt == CW'(HALF - 1) && rx) |=> (st == RX_IDLE && !done));

  // R9: a low stop sample ends the character with an error
  assert_stop_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_STOP && tick && cnt == CW'(OSR - 1) && !rx) |=> (done && ferr));
endmodule

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter
  import mdrop_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic          ferr,
  input  logic          mpbit,
  input  logic [DW-1:0] rx_data,
  input  logic          mp_en,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] node_addr,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data_q,
  output logic          new_frame,
  output logic          frame_err,
  output logic          overrun
);
  logic match_q, hit, pass, load;

  always_comb begin
    hit  = (rx_data == node_addr);
    pass = 1'b0;
    if (!mp_en) begin
      pass = 1'b1;
    end else begin
      case (filt_mode_e'(mode))
        FM_ALL:   pass = 1'b1;
        FM_ADDR:  pass = mpbit;
        FM_MATCH: pass = mpbit ? hit : match_q;
        FM_DATA:  pass = !mpbit && match_q;
      endcase
    end
    load = done && !ferr && pass;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q   <= 1'b0;
      valid     <= 1'b0;
      data_q    <= '0;
      new_frame <= 1'b0;
      frame_err <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (done) begin
        frame_err <= ferr;
        if (ferr) begin
          match_q <= 1'b0;
        end else begin
          new_frame <= mpbit;
          if (mpbit) match_q <= hit;
        end
      end
      if (valid && ready) begin
        valid   <= 1'b0;
        overrun <= 1'b0;
      end
      if (load) begin
        valid  <= 1'b1;
        data_q <= rx_data;
        if (valid && !ready) overrun <= 1'b1;
      end
    end
  end

  // R11: a held byte stays put until it is consumed
  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> (valid && $stable(data_q)));

  // R11: a handshake with no new byte empties the output
  assert_consume_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !load) |=> !valid);

  // R12: overwriting a held byte flags overrun
  assert_overrun_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (load && valid && !ready) |=> (overrun && valid));

  // R9: a framing error never produces a byte
  assert_ferr_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ferr && !valid) |=> (!valid && frame_err));

  // R5: in address-only mode a newly raised request is an address byte
  assert_addr_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(valid) && $past(mp_en) && $past(mode) == FM_ADDR) |-> new_frame);

  // R7: in data-only mode a newly raised request is a data byte
  assert_data_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(valid) && $past(mp_en) && $past(mode) == FM_DATA) |-> !new_frame);
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx #(
  parameter int OSR       = 16,
  parameter int DW        = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_line,
  input  logic          os_tick,
  input  logic          mp_en,
  input  logic [1:0]    filt_mode,
  input  logic [DW-1:0] node_addr,
  input  logic          two_stop,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          new_frame,
  output logic          frame_err,
  output logic          overrun
);
  logic          rx_s;
  logic          c_done, c_ferr, c_mp;
  logic [DW-1:0] c_data;

  mdrop_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(rx_line), .q(rx_s)
  );

  mdrop_rx_deser #(.OSR(OSR), .DW(DW)) u_deser (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s),
    .nine_en(mp_en), .two_stop(two_stop),
    .done(c_done), .ferr(c_ferr), .mpbit(c_mp), .data(c_data)
  );

  mdrop_rx_filter #(.DW(DW)) u_filter (
    .clk(clk), .rst_n(rst_n), .done(c_done), .ferr(c_ferr), .mpbit(c_mp),
    .rx_data(c_data), .mp_en(mp_en), .mode(filt_mode), .node_addr(node_addr),
    .ready(out_ready), .valid(out_valid), .data_q(out_data),
    .new_frame(new_frame), .frame_err(frame_err), .overrun(overrun)
  );
endmodule

// File: tb/test_mdrop_rx.sv
module test_mdrop_rx;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       os_tick = 1'b0;
  logic       mp_en = 1'b0;
  logic [1:0] filt_mode = 2'b00;
  logic [7:0] node_addr = 8'h00;
  logic       two_stop = 1'b0;
  logic       out_ready = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       new_frame, frame_err, overrun;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic       m_valid = 0, m_match = 0, m_nf = 0, m_ferr = 0, m_ovr = 0;
  logic [7:0] m_data = 8'h00;

  mdrop_rx i_mdrop_rx (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .mp_en(mp_en), .filt_mode(filt_mode), .node_addr(node_addr),
    .two_stop(two_stop), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .new_frame(new_frame), .frame_err(frame_err),
    .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) os_tick <= ~os_tick;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic accepts(input logic mpe, input logic [1:0] md,
                                   input logic mp, input logic hit, input logic armed);
    if (!mpe) return 1'b1;
    case (md)
      2'b00:   return 1'b1;
      2'b01:   return mp;
      2'b10:   return mp ? hit : armed;
      default: return !mp && armed;
    endcase
  endfunction

  function automatic string mode_tag(input logic bad);
    if (bad) return "R9";
    if (!mp_en) return "R3";
    case (filt_mode)
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic send_bit(input logic b);
    rx_line = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic compare_all(input string tag);
    chk(tag, {7'd0, out_valid}, {7'd0, m_valid});
    if (m_valid) chk("R1 data", out_data, m_data);
    chk("R8 new_frame", {7'd0, new_frame}, {7'd0, m_nf});
    chk({tag, " frame_err"}, {7'd0, frame_err}, {7'd0, m_ferr});
    chk("R12 overrun", {7'd0, overrun}, {7'd0, m_ovr});
  endtask

  task automatic frame(input logic [7:0] d, input logic mp, input logic bad1,
                       input logic bad2, input string tag);
    logic bad, hit, acc;
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (mp_en) send_bit(mp);
    send_bit(!bad1);
    if (two_stop && !bad1) send_bit(!bad2);
    rx_line = 1'b1;
    repeat (48) @(negedge clk);
    bad = bad1 || (two_stop && bad2);
    m_ferr = bad;
    if (bad) begin
      m_match = 1'b0;
    end else begin
      hit = (d == node_addr);
      acc = accepts(mp_en, filt_mode, mp_en & mp, hit, m_match);
      m_nf = mp_en & mp;
      if (mp_en && mp) m_match = hit;
      if (acc) begin
        if (m_valid) m_ovr = 1'b1;
        m_valid = 1'b1;
        m_data = d;
      end
    end
    compare_all((tag == "") ? mode_tag(bad) : tag);
  endtask

  task automatic do_read();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    @(negedge clk);
    m_valid = 1'b0;
    m_ovr = 1'b0;
    chk("R11 read", {7'd0, out_valid}, 8'd0);
    chk("R12 overrun clear", {7'd0, overrun}, 8'd0);
  endtask

  task automatic hold_check();
    logic [7:0] snap;
    snap = out_data;
    repeat (20) @(negedge clk);
    chk("R11 hold valid", {7'd0, out_valid}, 8'd1);
    chk("R11 hold data", out_data, snap);
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000 / CLK_PERIOD) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
    compare_all("R1 reset");

    // R2: glitch shorter than half a bit
    rx_line = 1'b0;
    repeat (6) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    compare_all("R2");

    // R3: plain 8-bit receive
    mp_en = 0;
    frame(8'hA5, 1'b0, 1'b0, 1'b0, "R3");
    hold_check();
    do_read();

    // R5: address bytes only
    mp_en = 1; filt_mode = 2'b01; node_addr = 8'h42;
    frame(8'h33, 1'b1, 1'b0, 1'b0, "R5 addr");
    do_read();
    frame(8'h10, 1'b0, 1'b0, 1'b0, "R5 data");

    // R4: everything passes
    filt_mode = 2'b00;
    frame(8'h5C, 1'b0, 1'b0, 1'b0, "R4 data");
    do_read();
    frame(8'h77, 1'b1, 1'b0, 1'b0, "R4 addr");
    do_read();

    // R6: matched address and following data
    filt_mode = 2'b10;
    frame(8'h41, 1'b1, 1'b0, 1'b0, "R6 mismatch");
    frame(8'h11, 1'b0, 1'b0, 1'b0, "R6 data unarmed");
    frame(8'h42, 1'b1, 1'b0, 1'b0, "R6 match");
    frame(8'h99, 1'b0, 1'b0, 1'b0, "R12 overwrite");
    do_read();

    // R9: bad stop disarms the match
    frame(8'h22, 1'b0, 1'b1, 1'b0, "R9 bad stop");
    frame(8'h23, 1'b0, 1'b0, 1'b0, "R9 after error");

    // R7: data after silent address
    filt_mode = 2'b11;
    frame(8'h42, 1'b1, 1'b0, 1'b0, "R7 addr silent");
    frame(8'hC3, 1'b0, 1'b0, 1'b0, "R7 data");
    do_read();

    // R10: second stop bit checked
    filt_mode = 2'b00; two_stop = 1;
    frame(8'h3A, 1'b0, 1'b0, 1'b1, "R10 bad second stop");
    frame(8'h3B, 1'b0, 1'b0, 1'b0, "R10 good");
    do_read();

    // random mix
    for (int n = 0; n < 80; n++) begin
      logic [7:0] d;
      mp_en     = ($urandom % 5) != 0;
      filt_mode = 2'($urandom % 4);
      node_addr = 8'h40 + 8'($urandom % 3);
      two_stop  = 1'($urandom % 2);
      d = (($urandom % 3) == 0) ? 8'h40 + 8'($urandom % 3) : 8'($urandom);
      frame(d, 1'($urandom % 2), ($urandom % 10) == 0, ($urandom % 10) == 0, "");
      if (($urandom % 10) < 7 && m_valid) do_read();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule